// File: doc/BRIEF.md
# Outbound window decoder

This block sits between a CPU-side memory bus and a PCI host bridge and decides, one address at a time, whether a CPU access falls into a PCI-bound window. The top 256 MB of the 32-bit space, from 0xF000_0000 upward, is cut into 32 slices of 8 MB each. A slice is forwarded only when the bridge is in the forwarding mode and the slice's bit in the enable mask is set. The decoder reports the hit and the slice number one clock after the address is presented.

A second, independent path classifies addresses issued by PCI bus masters into one of three targets: system RAM, the PCI memory alias, or the CPU local window. Addresses that match no target return a "none" code. Both mask and control are loaded through simple write strobes and act on the very next decoded address.

Top module: `outbound_window_decoder`

## Requirements
- R1: After reset the mask and control word are zero, `fwd_hit_o`, `fwd_chunk_o` and `in_tgt_o` read 0, and no CPU address is forwarded until both are written.
- R2: For a forwarded address the slice number on `fwd_chunk_o` equals (address − 0xF000_0000) / 0x0080_0000; hit and slice appear on the clock edge that follows the cycle in which the address is presented.
- R3: Forwarding requires control bits [8:7] to equal 2'b01; codes 2'b00, 2'b10 and 2'b11 block every slice, and no other control bit affects the result.
- R4: For slices 1 to 30, mask bit i set forwards slice i and mask bit i clear blocks it.
- R5: Slice 0 and slice 31 are never forwarded, whatever value bits 0 and 31 of the mask hold.
- R6: A mask or control write takes effect for an address presented in the cycle right after the write edge.
- R7: An address below 0xF000_0000, or any address with `out_valid_i` low, gives `fwd_hit_o` = 0 and `fwd_chunk_o` = 0; `fwd_chunk_o` is also 0 whenever `fwd_hit_o` is 0.
- R8: A valid inbound address below 0xF080_0000 yields `in_tgt_o` = 1 (system RAM).
- R9: A valid inbound address from 0xF080_0000 to 0xFF7F_FFFF (thirty slices) yields `in_tgt_o` = 2 (PCI alias).
- R10: A valid inbound address from 0xFFF0_0000 to 0xFFFF_FFFE yields `in_tgt_o` = 3 (CPU window).
- R11: Inbound addresses from 0xFF80_0000 to 0xFFEF_FFFF, the address 0xFFFF_FFFF, and any cycle with `in_valid_i` low yield `in_tgt_o` = 0; the target appears one edge after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_wr_i | input | 1 | Load strobe for the slice enable mask |
| en_wdata_i | input | 32 | New slice enable mask |
| ctl_wr_i | input | 1 | Load strobe for the control word |
| ctl_wdata_i | input | 32 | New control word; bits [8:7] hold the mode |
| out_valid_i | input | 1 | CPU address valid |
| out_addr_i | input | 32 | CPU address to decode |
| in_valid_i | input | 1 | Bus-master address valid |
| in_addr_i | input | 32 | Bus-master address to classify |
| fwd_hit_o | output | 1 | Registered: CPU address goes to PCI |
| fwd_chunk_o | output | 5 | Registered slice number of the hit, 0 otherwise |
| in_tgt_o | output | 2 | Registered inbound target: 0 none, 1 RAM, 2 PCI, 3 CPU |

## Verification
The assertions assume the address and valid inputs are stable for the whole cycle before the sampling edge and that a write strobe lasts exactly one cycle; they compare each registered output against the inputs and configuration seen one edge earlier. The bench drives every input on the falling edge and holds it across one rising edge, so that relation always holds. Stimulus sweeps every slice at its first, middle and last byte under several mask patterns and all four mode codes, and walks the inbound address space across each target boundary.

// File: rtl/owd_pkg.sv
package owd_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_RAM  = 2'd1,
    TGT_PCI  = 2'd2,
    TGT_CPU  = 2'd3
  } tgt_e;
endpackage

// File: rtl/owd_cfg_regs.sv
module owd_cfg_regs #(
  parameter int unsigned NUM_CHUNKS = 32,
  parameter int unsigned CTL_W      = 32,
  parameter int unsigned MODE_LSB   = 7,
  parameter logic [1:0]  MODE_CODE  = 2'b01
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_wr_i,
  input  logic [NUM_CHUNKS-1:0] en_wdata_i,
  input  logic                  ctl_wr_i,
  input  logic [CTL_W-1:0]      ctl_wdata_i,
  output logic [NUM_CHUNKS-1:0] en_eff_o,
  output logic                  fwd_on_o
);
  logic [NUM_CHUNKS-1:0] en_q;
  logic [CTL_W-1:0]      ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      ctl_q <= '0;
    end else begin
      if (en_wr_i)  en_q  <= en_wdata_i;
      if (ctl_wr_i) ctl_q <= ctl_wdata_i;
    end
  end

  // firmware slice and bridge slice are never exposed
  for (genvar i = 0; i < NUM_CHUNKS; i++) begin : g_eff
    if (i == 0 || i == NUM_CHUNKS - 1) begin : g_off
      assign en_eff_o[i] = 1'b0;
    end else begin : g_on
      assign en_eff_o[i] = en_q[i];
    end
  end

  assign fwd_on_o = (ctl_q[MODE_LSB+1:MODE_LSB] == MODE_CODE);

  // R6
  en_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_wr_i |=> en_q == $past(en_wdata_i));
  // R6
  ctl_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr_i |=> ctl_q == $past(ctl_wdata_i));
endmodule

// File: rtl/owd_out_dec.sv
module owd_out_dec #(
  parameter int unsigned        ADDR_W     = 32,
  parameter logic [ADDR_W-1:0]  WIN_BASE   = 32'hF000_0000,
  parameter int unsigned        CHUNK_W    = 23,
  parameter int unsigned        NUM_CHUNKS = 32,
  localparam int unsigned       IDX_W      = $clog2(NUM_CHUNKS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [NUM_CHUNKS-1:0] en_eff_i,
  input  logic                  fwd_on_i,
  output logic                  hit_o,
  output logic [IDX_W-1:0]      chunk_o
);
  logic [ADDR_W:0]    off;
  logic [ADDR_W-1:0]  slice_no;
  logic               in_win;
  logic [IDX_W-1:0]   idx;
  logic               hit_d;

  always_comb begin
    off      = {1'b0, addr_i} - {1'b0, WIN_BASE};
    slice_no = off[ADDR_W-1:0] >> CHUNK_W;
    in_win   = !off[ADDR_W] && (slice_no < ADDR_W'(NUM_CHUNKS));
    idx      = off[CHUNK_W +: IDX_W];
    hit_d    = valid_i && in_win && fwd_on_i && en_eff_i[idx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o   <= 1'b0;
      chunk_o <= '0;
    end else begin
      hit_o   <= hit_d;
      chunk_o <= hit_d ? idx : '0;
    end
  end

  // R3
  mode_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $past(fwd_on_i));
  // R5
  edge_slice_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (chunk_o != '0) && (chunk_o != IDX_W'(NUM_CHUNKS - 1)));
  // R4
  mask_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ((($past(en_eff_i) >> chunk_o) & NUM_CHUNKS'(1)) != '0));
  // R7
  valid_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $past(valid_i));
  // R7
  idle_chunk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> chunk_o == '0);
endmodule

// File: rtl/owd_in_dec.sv
module owd_in_dec
  import owd_pkg::*;
#(
  parameter int unsigned        ADDR_W     = 32,
  parameter logic [ADDR_W-1:0]  WIN_BASE   = 32'hF000_0000,
  parameter int unsigned        CHUNK_W    = 23,
  parameter int unsigned        NUM_CHUNKS = 32,
  parameter logic [ADDR_W-1:0]  CPU_BASE   = 32'hFFF0_0000,
  parameter logic [ADDR_W-1:0]  CPU_LAST   = 32'hFFFF_FFFE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  output tgt_e              tgt_o
);
  localparam longint unsigned CHUNK_SZ = 64'd1 << CHUNK_W;
  localparam longint unsigned PCI_LO   = 64'(WIN_BASE) + CHUNK_SZ;
  localparam longint unsigned PCI_HI   = PCI_LO + 64'(NUM_CHUNKS - 2) * CHUNK_SZ;

  logic [63:0] a64;
  tgt_e        tgt_d;

  always_comb begin
    a64 = 64'(addr_i);
    if (!valid_i)                                 tgt_d = TGT_NONE;
    else if (a64 < PCI_LO)                        tgt_d = TGT_RAM;
    else if (a64 < PCI_HI)                        tgt_d = TGT_PCI;
    else if (addr_i >= CPU_BASE && addr_i <= CPU_LAST) tgt_d = TGT_CPU;
    else                                          tgt_d = TGT_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tgt_o <= TGT_NONE;
    else         tgt_o <= tgt_d;
  end

  // R11
  tgt_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_o != TGT_NONE) |-> $past(valid_i));
  // R8
  ram_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_o == TGT_RAM) |-> (64'($past(addr_i)) < PCI_LO));
  // R10
  cpu_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_o == TGT_CPU) |-> ($past(addr_i) >= CPU_BASE && $past(addr_i) != '1));
endmodule

// File: rtl/outbound_window_decoder.sv
module outbound_window_decoder
  import owd_pkg::*;
#(
  parameter int unsigned        ADDR_W     = 32,
  parameter logic [ADDR_W-1:0]  WIN_BASE   = 32'hF000_0000,
  parameter int unsigned        CHUNK_W    = 23,
  parameter int unsigned        NUM_CHUNKS = 32,
  parameter int unsigned        CTL_W      = 32,
  parameter int unsigned        MODE_LSB   = 7,
  parameter logic [1:0]         MODE_CODE  = 2'b01,
  parameter logic [ADDR_W-1:0]  CPU_BASE   = 32'hFFF0_0000,
  parameter logic [ADDR_W-1:0]  CPU_LAST   = 32'hFFFF_FFFE,
  localparam int unsigned       IDX_W      = $clog2(NUM_CHUNKS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_wr_i,
  input  logic [NUM_CHUNKS-1:0] en_wdata_i,
  input  logic                  ctl_wr_i,
  input  logic [CTL_W-1:0]      ctl_wdata_i,
  input  logic                  out_valid_i,
  input  logic [ADDR_W-1:0]     out_addr_i,
  input  logic                  in_valid_i,
  input  logic [ADDR_W-1:0]     in_addr_i,
  output logic                  fwd_hit_o,
  output logic [IDX_W-1:0]      fwd_chunk_o,
  output logic [1:0]            in_tgt_o
);
  logic [NUM_CHUNKS-1:0] en_eff;
  logic                  fwd_on;
  tgt_e                  tgt;

  owd_cfg_regs #(
    .NUM_CHUNKS(NUM_CHUNKS), .CTL_W(CTL_W),
    .MODE_LSB(MODE_LSB), .MODE_CODE(MODE_CODE)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i),
    .ctl_wr_i(ctl_wr_i), .ctl_wdata_i(ctl_wdata_i),
    .en_eff_o(en_eff), .fwd_on_o(fwd_on)
  );

  owd_out_dec #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE),
    .CHUNK_W(CHUNK_W), .NUM_CHUNKS(NUM_CHUNKS)
  ) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .valid_i(out_valid_i), .addr_i(out_addr_i),
    .en_eff_i(en_eff), .fwd_on_i(fwd_on),
    .hit_o(fwd_hit_o), .chunk_o(fwd_chunk_o)
  );

  owd_in_dec #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .CHUNK_W(CHUNK_W),
    .NUM_CHUNKS(NUM_CHUNKS), .CPU_BASE(CPU_BASE), .CPU_LAST(CPU_LAST)
  ) u_in (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .valid_i(in_valid_i), .addr_i(in_addr_i),
    .tgt_o(tgt)
  );

  assign in_tgt_o = tgt;

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |=> !fwd_hit_o || $past(rst_ni));
endmodule

// File: tb/sim_outbound_window_decoder.sv
`timescale 1ns/1ps
module sim_outbound_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_wr = 1'b0, ctl_wr = 1'b0;
  logic [31:0] en_wdata = '0, ctl_wdata = '0;
  logic        out_valid = 1'b0, in_valid = 1'b0;
  logic [31:0] out_addr = '0, in_addr = '0;
  logic        fwd_hit;
  logic [4:0]  fwd_chunk;
  logic [1:0]  in_tgt;

  int n_run = 0, n_fail = 0;
  logic [31:0] mask_m = '0, ctl_m = '0;

  always #10 clk = ~clk;

  outbound_window_decoder u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .en_wr_i(en_wr), .en_wdata_i(en_wdata),
    .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata),
    .out_valid_i(out_valid), .out_addr_i(out_addr),
    .in_valid_i(in_valid), .in_addr_i(in_addr),
    .fwd_hit_o(fwd_hit), .fwd_chunk_o(fwd_chunk), .in_tgt_o(in_tgt)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // called at a falling edge; leaves the bench at the next falling edge
  task automatic wr_mask(input logic [31:0] v);
    en_wr = 1'b1; en_wdata = v; @(negedge clk); en_wr = 1'b0; mask_m = v;
  endtask
  task automatic wr_ctl(input logic [31:0] v);
    ctl_wr = 1'b1; ctl_wdata = v; @(negedge clk); ctl_wr = 1'b0; ctl_m = v;
  endtask

  task automatic probe_out(input logic [31:0] a, input bit v, input string req);
    logic [4:0] idx;
    bit         eh;
    logic [4:0] ec;
    out_valid = v; out_addr = a;
    @(negedge clk);
    idx = 5'((a - 32'hF000_0000) / 32'h0080_0000);
    eh  = v && (a >= 32'hF000_0000) && (ctl_m[8:7] == 2'b01) &&
          idx != 5'd0 && idx != 5'd31 && mask_m[idx];
    ec  = eh ? idx : 5'd0;
    chk(fwd_hit == eh, {req, " hit"}, 32'(fwd_hit), 32'(eh));
    chk(fwd_chunk == ec, {req, " chunk"}, 32'(fwd_chunk), 32'(ec));
    out_valid = 1'b0;
  endtask

  task automatic probe_in(input logic [31:0] a, input bit v, input string req);
    logic [1:0] et;
    in_valid = v; in_addr = a;
    @(negedge clk);
    if (!v)                                        et = 2'd0;
    else if (a < 32'hF080_0000)                    et = 2'd1;
    else if (a < 32'hFF80_0000)                    et = 2'd2;
    else if (a >= 32'hFFF0_0000 && a != '1)        et = 2'd3;
    else                                           et = 2'd0;
    chk(in_tgt == et, req, 32'(in_tgt), 32'(et));
    in_valid = 1'b0;
  endtask

  task automatic sweep_slices(input string req);
    for (int c = 0; c < 32; c++) begin
      logic [31:0] b = 32'hF000_0000 + 32'(c) * 32'h0080_0000;
      probe_out(b, 1'b1, req);
      probe_out(b + 32'h0040_0123, 1'b1, req);
      probe_out(b + 32'h007F_FFFF, 1'b1, req);
    end
  endtask

  initial begin
    #(20ns * 150000);
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs idle under reset
    chk(fwd_hit == 1'b0 && fwd_chunk == 5'd0 && in_tgt == 2'd0, "R1 reset outputs",
        {25'd0, fwd_hit, fwd_chunk, in_tgt}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: nothing forwarded before configuration
    for (int c = 0; c < 32; c++) probe_out(32'hF000_0000 + 32'(c) * 32'h0080_0000, 1'b1, "R1 unconfigured");

    // R2 R4 R5: full mask, mode 01
    wr_ctl(32'h0000_0080);
    wr_mask(32'hFFFF_FFFF);
    sweep_slices("R2 R4 R5 full mask");

    // R3: other mode codes block, unrelated control bits ignored
    wr_ctl(32'h0000_0000); sweep_slices("R3 mode 00");
    wr_ctl(32'h0000_0100); sweep_slices("R3 mode 10");
    wr_ctl(32'h0000_0180); sweep_slices("R3 mode 11");
    wr_ctl(32'hFFFF_FEFF); sweep_slices("R3 mode 01 other bits set");

    // R4 R5: patterned masks
    wr_ctl(32'h0000_0080);
    wr_mask(32'h5555_5555); sweep_slices("R4 mask 5555");
    wr_mask(32'hAAAA_AAAA); sweep_slices("R4 mask AAAA");
    wr_mask(32'h8000_0001); sweep_slices("R5 edge bits only");
    for (int b = 0; b < 32; b++) begin
      wr_mask(32'd1 << b);
      probe_out(32'hF000_0000 + 32'(b) * 32'h0080_0000 + 32'h10, 1'b1, "R4 R5 walking bit");
    end

    // R6: write then probe in the very next cycle
    wr_mask(32'h0000_0000);
    wr_mask(32'h0000_0400);
    probe_out(32'hF500_0000, 1'b1, "R6 mask takes effect");
    wr_ctl(32'h0000_0000);
    probe_out(32'hF500_0000, 1'b1, "R6 ctl disables");
    wr_ctl(32'h0000_0080);
    probe_out(32'hF500_0000, 1'b1, "R6 ctl enables");

    // R7: below window and valid low
    wr_mask(32'hFFFF_FFFF);
    probe_out(32'h0000_0000, 1'b1, "R7 low");
    probe_out(32'hEFFF_FFFF, 1'b1, "R7 below base");
    probe_out(32'h8000_0000, 1'b1, "R7 mid space");
    probe_out(32'hF500_0000, 1'b0, "R7 valid low");
    probe_out(32'hF080_0000, 1'b1, "R7 first open slice");

    // R8 R9 R10 R11: inbound boundaries
    probe_in(32'h0000_0000, 1'b1, "R8 zero");
    probe_in(32'hF07F_FFFF, 1'b1, "R8 top of RAM");
    probe_in(32'hF080_0000, 1'b1, "R9 PCI low");
    probe_in(32'hFF7F_FFFF, 1'b1, "R9 PCI high");
    probe_in(32'hFF80_0000, 1'b1, "R11 gap low");
    probe_in(32'hFFEF_FFFF, 1'b1, "R11 gap high");
    probe_in(32'hFFF0_0000, 1'b1, "R10 CPU low");
    probe_in(32'hFFFF_FFFE, 1'b1, "R10 CPU high");
    probe_in(32'hFFFF_FFFF, 1'b1, "R11 all ones");
    probe_in(32'hF100_0000, 1'b0, "R11 valid low");
    // R8 R9 R10 R11: coarse sweep
    for (int k = 0; k < 512; k++) probe_in((32'(k) << 23) | 32'h0070_0000, 1'b1, "R8 R9 R10 R11 sweep");
    for (int k = 0; k < 16; k++) probe_in(32'hFF70_0000 + 32'(k) * 32'h0010_0000, 1'b1, "R9 R10 R11 top sweep");

    summary();
  end
endmodule